// File: doc/BRIEF.md
# Parallel Suffix-Sum Doubling Engine

This block turns a vector of N integers into the vector of its suffix sums. After a run, element i of the result holds the sum of input elements i through N-1. Every element lives in its own lane, and all lanes update together in lockstep. The engine uses recursive doubling. The partner distance starts at 1 and doubles after each round. This means the whole vector is reduced in log2(N) single-cycle rounds, not in N-1 sequential additions.

To use the block, pulse the start input for one cycle while the engine is idle and present the whole vector on the parallel load bus in that same cycle. The engine then stays busy for log2(N) cycles. It raises done for one cycle once the final round has been written. The result bus is valid while done is high, and it keeps its value until the next accepted start.

Top module: `sfx_doubling_engine`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy and done are 0 and every result lane reads 0.
- R2: A start seen on a rising edge while busy is 0 loads lane i from bits [i*DW+DW-1 : i*DW] of the load bus, and busy is 1 from the next cycle on.
- R3: Exactly log2(N) rounds follow a load. The round index k runs 0, 1, ... log2(N)-1 and gives a partner distance of 2^k. done rises on the edge that writes the last round, which is log2(N) rising edges after the loading edge, and busy falls on that same edge.
- R4: When done is 1, result lane i (bits [i*DW+DW-1 : i*DW]) equals the sum of input lanes i through N-1.
- R5: In a round with distance s, a lane i with i+s >= N keeps its value. As a result, lane N-1 always returns its loaded value unchanged.
- R6: In a round, a lane with i+s < N adds the value that lane i+s held before that round. No lane uses a value written in the same round.
- R7: A start that arrives while busy is 1 is ignored. The rounds in progress, the timing of done and the final result are unaffected.
- R8: done is high for exactly one cycle. While the engine is idle and no start arrives, the result bus does not change.
- R9: Every addition wraps modulo 2^DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, accepted only while idle |
| vec_in | input | N*DW | Parallel load vector, lane 0 in the low bits |
| result_o | output | N*DW | Lane values, lane 0 in the low bits |
| busy_o | output | 1 | High while rounds are in progress |
| done_o | output | 1 | One-cycle pulse after the final round |

## Verification
The assertions make three assumptions about the inputs. N is a power of two no smaller than 2. start may be asserted at any time, including while busy. vec_in matters only in the cycle where a start is accepted. The stimulus respects these assumptions. It keeps N at its default power of two. It changes vec_in freely between loads. It deliberately raises start with a different vector during a run to exercise the ignore path. It also uses all-ones and high-bit patterns so that the wrap behaviour is exercised rather than avoided.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    // Engine phase: idle waits for start, round performs one doubling step per cycle
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ROUND = 1'b1
    } phase_e;

    // Partner distance for a given round index
    function automatic int unsigned stride_of(input int unsigned k);
        return 32'd1 << k;
    endfunction

    // True when a lane has a partner inside the vector for this round
    function automatic bit partner_inside(input int unsigned lane,
                                          input int unsigned k,
                                          input int unsigned lanes);
        return (lane + stride_of(k)) < lanes;
    endfunction

endpackage

// File: rtl/sfx_round_ctrl.sv
module sfx_round_ctrl
    import sfx_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    output logic                         load_o,
    output logic                         step_o,
    output logic [$clog2(LANES)-1:0]     rnd_o,
    output logic                         busy_o,
    output logic                         done_o
);
    localparam int unsigned RW     = $clog2(LANES);
    localparam int unsigned ROUNDS = RW;
    localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS - 1);

    phase_e          phase_q;
    logic [RW-1:0]   rnd_q;
    logic            done_q;
    logic            last_rnd;

    assign last_rnd = (rnd_q == LAST_RND);
    assign load_o   = (phase_q == PH_IDLE) && start;
    assign step_o   = (phase_q == PH_ROUND);
    assign rnd_o    = rnd_q;
    assign busy_o   = (phase_q == PH_ROUND);
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rnd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_ROUND;
                        rnd_q   <= '0;
                    end
                end
                PH_ROUND: begin
                    if (last_rnd) begin
                        phase_q <= PH_IDLE;
                        rnd_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        rnd_q <= rnd_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (rnd_q <= LAST_RND)); // R3
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (busy_o && last_rnd) |=> (done_o && !busy_o)); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start && !last_rnd) |=> (busy_o && rnd_q == $past(rnd_q) + 1'b1)); // R7

endmodule

// File: rtl/sfx_lane.sv
module sfx_lane
    import sfx_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned IDX   = 0
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               load,
    input  logic                               step,
    input  logic [$clog2(LANES)-1:0]           rnd,
    input  logic [DW-1:0]                      init,
    input  logic [LANES-1:0][DW-1:0]           all_vals,
    output logic [DW-1:0]                      val_o
);
    localparam int unsigned RW     = $clog2(LANES);
    localparam int unsigned ROUNDS = RW;

    logic [ROUNDS-1:0][DW-1:0] cand;
    logic [ROUNDS-1:0]         ok;
    logic [DW-1:0]             partner;
    logic                      en;
    logic [DW-1:0]             val_q;

    // One candidate partner per round; rounds whose partner lies past the top are tied off
    for (genvar k = 0; k < ROUNDS; k++) begin : g_cand
        if (partner_inside(IDX, k, LANES)) begin : g_in
            assign cand[k] = all_vals[IDX + stride_of(k)];
            assign ok[k]   = 1'b1;
        end else begin : g_out
            assign cand[k] = '0;
            assign ok[k]   = 1'b0;
        end
    end

    always_comb begin
        partner = '0;
        en      = 1'b0;
        for (int k = 0; k < ROUNDS; k++) begin
            if (rnd == RW'(k)) begin
                partner = cand[k];
                en      = step && ok[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (load) begin
            val_q <= init;
        end else if (en) begin
            val_q <= val_q + partner;
        end
    end

    assign val_o = val_q;

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step && !en) |=> (val_q == $past(val_q))); // R5
    AST_LANE_OLD_OPERAND: assert property (@(posedge clk) disable iff (rst)
        en |=> (val_q == DW'($past(val_q) + $past(partner)))); // R6

endmodule

// File: rtl/sfx_doubling_engine.sv
module sfx_doubling_engine
    import sfx_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned DW    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [LANES*DW-1:0]   vec_in,
    output logic [LANES*DW-1:0]   result_o,
    output logic                  busy_o,
    output logic                  done_o
);
    localparam int unsigned RW = $clog2(LANES);

    logic                       load;
    logic                       step;
    logic [RW-1:0]              rnd;
    logic [LANES-1:0][DW-1:0]   vin;
    logic [LANES-1:0][DW-1:0]   vals;

    assign vin      = vec_in;
    assign result_o = vals;

    initial begin
        AST_LANES_POW2: assert (LANES >= 2 && (LANES & (LANES - 1)) == 0); // R3
    end

    sfx_round_ctrl #(.LANES(LANES)) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .load_o (load),
        .step_o (step),
        .rnd_o  (rnd),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sfx_lane #(.LANES(LANES), .DW(DW), .IDX(i)) lane_i (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .step     (step),
            .rnd      (rnd),
            .init     (vin[i]),
            .all_vals (vals),
            .val_o    (vals[i])
        );
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start) |=> $stable(result_o)); // R8
    AST_TOP_LANE_FIXED: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (vals[LANES-1] == $past(vals[LANES-1]))); // R5

endmodule

// File: tb/sfx_doubling_engine_tb_top.sv
`timescale 1ns/1ps
module sfx_doubling_engine_tb_top;
    localparam int unsigned N  = 16;
    localparam int unsigned DW = 16;
    localparam int unsigned L  = $clog2(N);

    typedef struct packed {
        logic [DW-1:0] base;
        logic [DW-1:0] incr;
    } pat_t;

    // Stimulus table: lane i = base + i*incr
    localparam pat_t TBL [6] = '{
        '{16'h0000, 16'h0000},
        '{16'h0001, 16'h0000},
        '{16'h0000, 16'h0001},
        '{16'h1234, 16'h0101},
        '{16'hFFFF, 16'h0000},
        '{16'h8000, 16'h8000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [N*DW-1:0]   vec_in = '0;
    logic [N*DW-1:0]   result_o;
    logic              busy_o;
    logic              done_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sfx_doubling_engine #(.LANES(N), .DW(DW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .vec_in   (vec_in),
        .result_o (result_o),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    function automatic logic [N*DW-1:0] model(input logic [N*DW-1:0] v);
        logic [N*DW-1:0] r;
        logic [DW-1:0]   acc;
        r   = '0;
        acc = '0;
        for (int i = N - 1; i >= 0; i--) begin
            acc = acc + v[i*DW +: DW];
            r[i*DW +: DW] = acc;
        end
        return r;
    endfunction

    function automatic logic [N*DW-1:0] from_pat(input pat_t p);
        logic [N*DW-1:0] v;
        for (int i = 0; i < N; i++) v[i*DW +: DW] = p.base + DW'(i) * p.incr;
        return v;
    endfunction

    task automatic check(input string req, input logic [N*DW-1:0] act,
                         input logic [N*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One run: load at a rising edge, then follow each round edge
    task automatic run_vec(input logic [N*DW-1:0] v, input bit intrude, input string tag);
        logic [N*DW-1:0] exp;
        exp = model(v);
        @(negedge clk);
        start  = 1'b1;
        vec_in = v;
        @(negedge clk);                       // after loading edge
        start  = 1'b0;
        vec_in = ~v;
        check({"R2 busy after load ", tag}, busy_o, 1);
        for (int j = 1; j <= L; j++) begin
            if (intrude && j == 1) begin
                start  = 1'b1;
                vec_in = {N{16'h5A5A}};
            end
            @(negedge clk);                   // after round edge j
            start = 1'b0;
            if (j < L) begin
                check({"R3 no early done ", tag}, done_o, 0);
                check({"R3 busy mid run ", tag}, busy_o, 1);
            end else begin
                check({"R3 done after last round ", tag}, done_o, 1);
                check({"R3 busy falls ", tag}, busy_o, 0);
                check({intrude ? "R7 ignored start result " : "R4 R6 R9 suffix sums ", tag},
                      result_o, exp);
                check({"R5 top lane unchanged ", tag}, result_o[(N-1)*DW +: DW],
                      v[(N-1)*DW +: DW]);
            end
        end
        @(negedge clk);
        check({"R8 done single cycle ", tag}, done_o, 0);
        check({"R8 result held ", tag}, result_o, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy_o, 0);
        check("R1 done in reset", done_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 result after reset", result_o, '0);
        check("R1 busy after reset", busy_o, 0);

        foreach (TBL[t]) run_vec(from_pat(TBL[t]), 1'b0, $sformatf("table%0d", t));

        // R9: all ones wraps to -(N-i)
        begin
            logic [N*DW-1:0] ones, wexp;
            ones = '1;
            for (int i = 0; i < N; i++) wexp[i*DW +: DW] = DW'(0) - DW'(N - i);
            run_vec(ones, 1'b0, "wrap");
            check("R9 wrap explicit", result_o, wexp);
        end

        // R5/R6: single nonzero element at lane 0 stays only in lane 0
        begin
            logic [N*DW-1:0] one0, e0;
            one0 = '0; one0[DW-1:0] = 16'd7;
            e0 = '0;  e0[DW-1:0]   = 16'd7;
            run_vec(one0, 1'b0, "lane0");
            check("R6 lane0 only", result_o, e0);
        end

        run_vec(from_pat(TBL[3]), 1'b1, "intrude");

        for (int r = 0; r < 20; r++) begin
            logic [N*DW-1:0] rv;
            for (int i = 0; i < N; i++) rv[i*DW +: DW] = DW'($urandom);
            run_vec(rv, 1'b0, $sformatf("rand%0d", r));
        end

        // Reset in the middle of a run
        @(negedge clk);
        start = 1'b1; vec_in = from_pat(TBL[3]);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 busy after mid-run reset", busy_o, 0);
        check("R1 done after mid-run reset", done_o, 0);
        check("R1 result after mid-run reset", result_o, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule